// File: doc/BRIEF.md
# Block Check Accumulator for Character-Oriented Synchronous Links

This unit keeps the running block check of a character-oriented synchronous frame and handles one character per strobe. It supports two check types. The first is a 7-bit longitudinal XOR check (LRC) over the character data bits. The second is a 16-bit cyclic check with generator x^16 + x^15 + x^2 + 1. The cyclic check is used whenever CRC mode is selected, and also whenever the receiver is in transparent mode. A preset strobe loads the starting value. For LRC, zeros give an even check and ones give an odd check.

The unit holds two check registers. The running register includes the character just presented. The committed register holds the value from before that character. After looking at the character, the surrounding logic sends a decision. "Keep" moves the running value into the committed register. "Drop" restores the running register from the committed one, so the character leaves no trace in the check.

The transmit side reads the check value to send. In LRC mode it also reads a parity-completed character and a parity-completed LRC byte. The receive side feeds the received check characters through the unit and reads a good-block flag.

Top module: `blk_check_unit`

## Requirements
- R1: One clock after `presetStb`, both `runVal` and `checkVal` equal the preset. In CRC mode all 16 bits of `presetVal` are loaded. In LRC mode only `presetVal[6:0]` is loaded and bits 15:7 are zero.
- R2: In LRC mode (`crcMode`=0, `transparent`=0), one clock after `charStb`, `runVal` equals `{9'b0, checkVal[6:0] ^ charData[6:0]}`. Bit 7 of the character is ignored.
- R3: In CRC mode, one clock after `charStb`, `runVal` is `checkVal` advanced by the 8 bits of `charData`, least significant bit first, using the reflected generator 0xA001 with no inversion. With preset 0, the ASCII string "123456789" gives 0xBB3D.
- R4: When `transparent`=1, the CRC computation of R3 applies even if `crcMode`=0.
- R5: One clock after `keepStb` with `keepChar`=1, `checkVal` takes the former `runVal`. One clock after `keepStb` with `keepChar`=0, `runVal` takes the former `checkVal`.
- R6: Strobe priority is preset, then decision, then character. A character strobe never changes `checkVal`. A cycle with no strobe changes neither register.
- R7: `blockGood` is 1 exactly when the committed value is zero over the active width: all 16 bits in CRC mode, bits 6:0 in LRC mode. After a CRC of a block followed by its two check bytes (low byte first) has been kept, `blockGood` is 1.
- R8: One clock after `charStb`, `charParity` equals `{p, charData[6:0]}`, where p = XOR of `charData[6:0]` XOR `oddParity`. So `oddParity`=1 makes the total number of ones odd.
- R9: `lrcChar` equals `{XOR of checkVal[6:0] XOR oddParity, checkVal[6:0]}` at all times. Parity is applied only to the finished LRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| presetStb | input | 1 | Load preset into both registers |
| presetVal | input | 16 | Preset value |
| crcMode | input | 1 | 1 = CRC16, 0 = LRC |
| transparent | input | 1 | Transparent receive, forces CRC16 |
| oddParity | input | 1 | Parity sense, 1 = odd |
| charStb | input | 1 | Character valid |
| charData | input | 8 | Character |
| keepStb | input | 1 | Decision valid for last character |
| keepChar | input | 1 | 1 = include, 0 = drop |
| runVal | output | 16 | Check including last character |
| checkVal | output | 16 | Committed check |
| blockGood | output | 1 | Committed check is zero |
| charParity | output | 8 | Last character with parity bit |
| lrcChar | output | 8 | Committed LRC with parity bit |

## Verification
Every register result is due exactly one clock after its strobe. This covers `runVal`, `checkVal` and `charParity`. `blockGood` and `lrcChar` follow `checkVal` combinationally within that same cycle. The bench therefore drives a strobe just after a falling edge, drops it at the next falling edge, and samples at that falling edge. That is half a period after the single rising edge that must update the registers. Expected CRC values come from a bitwise reference model in the bench and from the known test string.

// File: rtl/blk_check_pkg.sv
package blk_check_pkg;
  localparam int unsigned CharW = 8;
  localparam int unsigned CrcW  = 16;
  localparam int unsigned LrcW  = 7;
  localparam logic [CrcW-1:0] CrcPolyRefl = 16'hA001;

  typedef struct packed {
    logic loadPreset;
    logic commit;
    logic revert;
    logic stepChar;
  } ctlStrobes_t;
endpackage

// File: rtl/blk_check_ctl.sv
module blk_check_ctl
  import blk_check_pkg::*;
(
  input  logic        presetStb,
  input  logic        charStb,
  input  logic        keepStb,
  input  logic        keepChar,
  input  logic        crcMode,
  input  logic        transparent,
  output ctlStrobes_t strobes,
  output logic        crcActive
);
  always_comb begin
    strobes = '0;
    if (presetStb) begin
      strobes.loadPreset = 1'b1;
    end else if (keepStb) begin
      strobes.commit = keepChar;
      strobes.revert = ~keepChar;
    end else if (charStb) begin
      strobes.stepChar = 1'b1;
    end
  end

  assign crcActive = crcMode | transparent;
endmodule

// File: rtl/blk_check_dp.sv
module blk_check_dp
  import blk_check_pkg::*;
#(
  parameter int unsigned DataW = CharW,
  parameter int unsigned ChkW  = CrcW,
  parameter int unsigned LrcBits = LrcW,
  parameter logic [ChkW-1:0] PolyRefl = CrcPolyRefl
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             crcActive,
  input  logic             oddParity,
  input  logic             charStb,
  input  logic [DataW-1:0] charData,
  input  logic [ChkW-1:0]  presetVal,
  output logic [ChkW-1:0]  runVal,
  output logic [ChkW-1:0]  checkVal,
  output logic [DataW-1:0] charParity
);
  localparam int unsigned PadW = ChkW - LrcBits;

  logic [ChkW-1:0] runQ, commitQ, crcNext, lrcNext, stepNext, presetEff;
  logic [DataW-1:0] parQ;

  function automatic logic [ChkW-1:0] crcByte(input logic [ChkW-1:0] seed,
                                              input logic [DataW-1:0] din);
    logic [ChkW-1:0] acc;
    acc = seed;
    for (int b = 0; b < DataW; b++) begin
      if (acc[0] ^ din[b]) acc = (acc >> 1) ^ PolyRefl;
      else                 acc = acc >> 1;
    end
    return acc;
  endfunction

  always_comb begin
    crcNext   = crcByte(commitQ, charData);
    lrcNext   = {{PadW{1'b0}}, commitQ[LrcBits-1:0] ^ charData[LrcBits-1:0]};
    stepNext  = crcActive ? crcNext : lrcNext;
    presetEff = crcActive ? presetVal : {{PadW{1'b0}}, presetVal[LrcBits-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ    <= '0;
      commitQ <= '0;
    end else if (strobes.loadPreset) begin
      runQ    <= presetEff;
      commitQ <= presetEff;
    end else if (strobes.commit) begin
      commitQ <= runQ;
    end else if (strobes.revert) begin
      runQ <= commitQ;
    end else if (strobes.stepChar) begin
      runQ <= stepNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) parQ <= '0;
    else if (charStb)
      parQ <= {(^charData[LrcBits-1:0]) ^ oddParity, charData[LrcBits-1:0]};
  end

  assign runVal     = runQ;
  assign checkVal   = commitQ;
  assign charParity = parQ;
endmodule

// File: rtl/blk_check_unit.sv
module blk_check_unit
  import blk_check_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        presetStb,
  input  logic [15:0] presetVal,
  input  logic        crcMode,
  input  logic        transparent,
  input  logic        oddParity,
  input  logic        charStb,
  input  logic [7:0]  charData,
  input  logic        keepStb,
  input  logic        keepChar,
  output logic [15:0] runVal,
  output logic [15:0] checkVal,
  output logic        blockGood,
  output logic [7:0]  charParity,
  output logic [7:0]  lrcChar
);
  ctlStrobes_t strobes;
  logic crcActive;

  blk_check_ctl u_ctl (
    .presetStb(presetStb), .charStb(charStb), .keepStb(keepStb),
    .keepChar(keepChar), .crcMode(crcMode), .transparent(transparent),
    .strobes(strobes), .crcActive(crcActive)
  );

  blk_check_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .crcActive(crcActive),
    .oddParity(oddParity), .charStb(charStb), .charData(charData),
    .presetVal(presetVal), .runVal(runVal), .checkVal(checkVal),
    .charParity(charParity)
  );

  assign blockGood = crcActive ? (checkVal == '0) : (checkVal[LrcW-1:0] == '0);
  assign lrcChar   = {(^checkVal[LrcW-1:0]) ^ oddParity, checkVal[LrcW-1:0]};
endmodule

// File: rtl/blk_check_chk.sv
module blk_check_chk (
  input logic        clk,
  input logic        rstN,
  input logic        presetStb,
  input logic        crcMode,
  input logic        transparent,
  input logic        charStb,
  input logic        keepStb,
  input logic        keepChar,
  input logic [15:0] runVal,
  input logic [15:0] checkVal,
  input logic        blockGood
);
  a_r1_preset_both: assert property (@(posedge clk) disable iff (!rstN)
    presetStb |=> runVal == checkVal);

  a_r2_lrc_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (charStb && !presetStb && !keepStb && !crcMode && !transparent) |=> runVal[15:7] == '0);

  a_r5_commit: assert property (@(posedge clk) disable iff (!rstN)
    (keepStb && keepChar && !presetStb) |=> checkVal == $past(runVal));

  a_r5_revert: assert property (@(posedge clk) disable iff (!rstN)
    (keepStb && !keepChar && !presetStb) |=> runVal == $past(checkVal));

  a_r6_char_keeps_commit: assert property (@(posedge clk) disable iff (!rstN)
    (charStb && !presetStb && !keepStb) |=> $stable(checkVal));

  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!charStb && !presetStb && !keepStb) |=> ($stable(checkVal) && $stable(runVal)));

  a_r7_good_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    blockGood |-> checkVal[6:0] == '0);
endmodule

bind blk_check_unit blk_check_chk u_chk (
  .clk(clk), .rstN(rstN), .presetStb(presetStb), .crcMode(crcMode),
  .transparent(transparent), .charStb(charStb), .keepStb(keepStb),
  .keepChar(keepChar), .runVal(runVal), .checkVal(checkVal),
  .blockGood(blockGood)
);

// File: tb/blk_check_unit_test.sv
module blk_check_unit_test;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic presetStb = 0, crcMode = 0, transparent = 0, oddParity = 0;
  logic charStb = 0, keepStb = 0, keepChar = 0;
  logic [15:0] presetVal = '0;
  logic [7:0]  charData = '0;
  logic [15:0] runVal, checkVal;
  logic blockGood;
  logic [7:0] charParity, lrcChar;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(ClkPeriod/2) clk = ~clk;

  blk_check_unit uut (.*);

  function automatic logic [15:0] refCrc(input logic [15:0] s, input logic [7:0] d);
    logic [15:0] c = s;
    for (int i = 0; i < 8; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'hA001;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doPreset(input logic [15:0] v);
    @(negedge clk); presetStb = 1; presetVal = v;
    @(negedge clk); presetStb = 0;
  endtask

  task automatic doChar(input logic [7:0] d);
    @(negedge clk); charStb = 1; charData = d;
    @(negedge clk); charStb = 0;
  endtask

  task automatic doKeep(input logic k);
    @(negedge clk); keepStb = 1; keepChar = k;
    @(negedge clk); keepStb = 0;
  endtask

  task automatic testReset();
    check("R1 reset runVal", runVal, 16'h0);
    check("R1 reset checkVal", checkVal, 16'h0);
    check("R7 reset good", {15'b0, blockGood}, 16'h1);
  endtask

  task automatic testLrc();
    crcMode = 0; transparent = 0; oddParity = 0;
    doPreset(16'hFFFF);
    check("R1 lrc preset run", runVal, 16'h007F);
    check("R1 lrc preset commit", checkVal, 16'h007F);
    doPreset(16'h0000);
    doChar(8'hC1);
    check("R2 lrc run bit7 ignored", runVal, 16'h0041);
    check("R6 char keeps commit", checkVal, 16'h0000);
    check("R8 even parity 0x41", {8'h0, charParity}, 16'h0041);
    doKeep(1);
    check("R5 commit", checkVal, 16'h0041);
    doChar(8'h43);
    check("R8 even parity 0x43", {8'h0, charParity}, 16'h00C3);
    doKeep(1);
    check("R2 lrc xor", checkVal, 16'h0002);
    check("R9 lrc char even", {8'h0, lrcChar}, 16'h0082);
    oddParity = 1;
    #1 check("R9 lrc char odd", {8'h0, lrcChar}, 16'h0002);
    doChar(8'h10);
    check("R8 odd parity 0x10", {8'h0, charParity}, 16'h0010);
    doKeep(0);
    check("R5 drop restores run", runVal, 16'h0002);
    check("R5 drop commit same", checkVal, 16'h0002);
    doChar(8'h02); doKeep(1);
    check("R7 lrc good", {15'b0, blockGood}, 16'h1);
    oddParity = 0;
  endtask

  task automatic testCrc();
    string s = "123456789";
    logic [15:0] m = 16'h0;
    crcMode = 1;
    doPreset(16'h0000);
    foreach (s[i]) begin
      doChar(s[i]); doKeep(1);
      m = refCrc(m, s[i]);
    end
    check("R3 crc model", checkVal, m);
    check("R3 crc vector", checkVal, 16'hBB3D);
    doChar(8'hAA);
    check("R3 crc run step", runVal, refCrc(16'hBB3D, 8'hAA));
    doKeep(0);
    check("R5 crc drop", runVal, 16'hBB3D);
    doChar(8'h3D); doKeep(1);
    doChar(8'hBB); doKeep(1);
    check("R7 crc good", {15'b0, blockGood}, 16'h1);
    doPreset(16'hFFFF);
    check("R1 crc preset full", checkVal, 16'hFFFF);
    check("R7 crc not good", {15'b0, blockGood}, 16'h0);
  endtask

  task automatic testTransparent();
    crcMode = 0; transparent = 1;
    doPreset(16'h0000);
    doChar(8'h31); doKeep(1);
    check("R4 transparent forces crc", checkVal, refCrc(16'h0, 8'h31));
    transparent = 0;
  endtask

  task automatic testPriority();
    crcMode = 0;
    doPreset(16'h0000);
    doChar(8'h05);
    @(negedge clk); presetStb = 1; presetVal = 16'h0011; keepStb = 1; keepChar = 1;
    charStb = 1; charData = 8'h7F;
    @(negedge clk); presetStb = 0; keepStb = 0; charStb = 0;
    check("R6 preset wins", checkVal, 16'h0011);
    check("R6 preset wins run", runVal, 16'h0011);
    doChar(8'h01);
    @(negedge clk); keepStb = 1; keepChar = 1; charStb = 1; charData = 8'h7F;
    @(negedge clk); keepStb = 0; charStb = 0;
    check("R6 decision over char", checkVal, 16'h0010);
    check("R6 char skipped", runVal, 16'h0010);
    repeat (3) @(negedge clk);
    check("R6 idle stable", runVal, 16'h0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLrc();
    testCrc();
    testTransparent();
    testPriority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule